// File: doc/BRIEF.md
# Serial-Bus Byte Store with Page Programming

This block is the slave side of a four-wire serial bus. It contains a byte-wide storage array that can be read and written. A host lowers the select line and shifts an opcode, a 24-bit address and data bytes in, most significant bit first. The block samples the serial input on rising serial-clock edges and drives its serial output on falling edges. The serial clock may idle either low or high while the block is deselected.

All bus pins are sampled in the system clock domain, which must run at least eight times faster than the serial clock. Reads stream bytes out continuously. Writes are collected into a page buffer and committed only when select rises cleanly. The commit runs during a self-timed busy interval that a cycle counter measures. Status bits choose a protected region at the top of the array. A lock pin guards the status register. A pause pin freezes a transfer in the middle without losing its place.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00. The output enable is low whenever select is high.
- R2: Every command works whether the serial clock idles low (mode 0) or high (mode 3) when select falls.
- R3: Opcode 0x06 sets the write-enable flag (status bit 1) and opcode 0x04 clears it. Opcode 0x05 returns the status byte on every following byte, laid out as {4'b0, protect[1:0] at bits 3:2, write-enable at bit 1, busy at bit 0}.
- R4: A page write (0x02) or a status write (0x01) issued while the write-enable flag is clear changes neither the array nor the status.
- R5: Data bytes of a page write advance only the low PAGE_W address bits. They wrap inside the addressed page, so a later byte replaces an earlier one at the same offset, and the next page is never touched.
- R6: A write commits only if select rises on a byte boundary after at least one complete data byte. An aborted write leaves the array and the write-enable flag unchanged.
- R7: During the busy interval the status reads busy=1. Every opcode other than 0x05 is ignored, so a read drives no output. When the interval ends, the write-enable flag clears and the new data is readable.
- R8: A read (0x03) streams bytes from the address and increments it. The address wraps from the last byte of the array to 0 while select stays low.
- R9: The protect field selects the protected region: 00 protects nothing, 01 the top quarter, 10 the top half, 11 the whole array. Bytes of a committed page write that fall in the protected region keep their old value.
- R10: A status write (0x01) takes data bits 3:2 as the new protect field. It is discarded while the lock pin is low.
- R11: While the pause pin is low, serial-clock and data activity is ignored and the output enable is low. After release, the transfer continues from the same bit.
- R12: Only the low ADDR_W bits of the 24-bit address are used. The higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Bus select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial data out of the block |
| ser_dout_en | output | 1 | High when ser_dout should be driven onto the bus |
| sr_lock_n | input | 1 | Low blocks status-register writes |
| pause_n | input | 1 | Low freezes the current transfer |

## Verification
The bench goes after page wrap-around. A design that carried into the next page would corrupt the neighbouring page, which the bench reads back. Writes are cut off mid-byte or sent with no data byte. A design that committed these would change bytes that the later read-back expects unchanged. A read is sent during the busy interval. A design that decoded it would raise the output enable. The bench also covers array-end wrap with junk upper address bits, each protect setting at its exact boundary, and a pause in the middle of a byte. A wrong boundary shows up as an overwritten protected byte. A pause that leaked edges would shift every later bit.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDATA,
    PH_WDATA,
    PH_RSTAT,
    PH_WSTAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/eep_serial.sv
module eep_serial (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csn,
  input  logic       sck,
  input  logic       mosi,
  input  logic       hold_n,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       tx_req,
  output logic       miso,
  output logic [2:0] bit_cnt
);
  logic       sck_q;
  logic [2:0] cnt_q, cnt_d;
  logic [6:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic       active, rise, fall;

  assign active    = ~csn & hold_n;
  assign rise      = active & sck & ~sck_q;
  assign fall      = active & ~sck & sck_q;
  assign tx_req    = fall & (cnt_q == 3'd0);
  assign byte_done = rise & (cnt_q == 3'd7);
  assign rx_byte   = {sh_q, mosi};
  assign miso      = tx_q[7];
  assign bit_cnt   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    tx_d  = tx_q;
    if (csn) begin
      cnt_d = 3'd0;
    end else if (rise) begin
      cnt_d = cnt_q + 3'd1;
      sh_d  = {sh_q[5:0], mosi};
    end
    if (fall) begin
      tx_d = (cnt_q == 3'd0) ? tx_byte : {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cnt_q <= 3'd0;
      sh_q  <= 7'd0;
      tx_q  <= 8'd0;
    end else begin
      sck_q <= sck;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      tx_q  <= tx_d;
    end
  end

  assert_deselect_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> (cnt_q == 3'd0));
  assert_pause_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !csn) |=> $stable(cnt_q));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 7,
  parameter int BUSY_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              wp_n,
  input  logic              hold_n,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              tx_req,
  input  logic [2:0]        bit_cnt,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        tx_byte,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [1:0]        bp_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PBW   = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  phase_t              phase_q, phase_d;
  logic [1:0]          acnt_q, acnt_d;
  logic                rd_q, rd_d, kind_q, kind_d, armed_q, armed_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [PAGE_W-1:0]   wptr_q, wptr_d;
  logic [PBW-1:0]      base_q, base_d;
  logic [PAGE-1:0]     mask_q, mask_d;
  logic [1:0]          srd_q, srd_d, bp_q, bp_d;
  logic                wel_q, wel_d, busy_q, busy_d, prog_q, prog_d, csn_q;
  logic [CNT_W-1:0]    bcnt_q, bcnt_d;
  logic                pb_we, cs_rise, in_page;
  logic [PAGE_W-1:0]   bofs;
  logic [7:0]          status;
  logic [7:0]          pbuf [PAGE];

  function automatic logic prot_hit(input logic [ADDR_W-1:0] a, input logic [1:0] bp);
    logic hit;
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &a[ADDR_W-1:ADDR_W-2];
      2'b10:   hit = a[ADDR_W-1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  assign cs_rise   = csn & ~csn_q;
  assign status    = {4'b0000, bp_q, wel_q, busy_q};
  assign bofs      = PAGE_W'(bcnt_q);
  assign in_page   = 32'(bcnt_q) < PAGE;
  assign mem_raddr = addr_q;
  assign mem_waddr = {base_q, bofs};
  assign mem_wdata = pbuf[bofs];
  assign mem_we    = busy_q & prog_q & in_page & mask_q[bofs] & ~prot_hit({base_q, bofs}, bp_q);
  assign so_oe     = ~csn & hold_n & ((phase_q == PH_RDATA) | (phase_q == PH_RSTAT));
  assign bp_o      = bp_q;

  always_comb begin
    phase_d = phase_q; acnt_d = acnt_q; rd_d = rd_q; kind_d = kind_q;
    armed_d = armed_q; addr_d = addr_q; wptr_d = wptr_q; base_d = base_q;
    mask_d = mask_q; srd_d = srd_q; bp_d = bp_q; wel_d = wel_q;
    busy_d = busy_q; prog_d = prog_q; bcnt_d = bcnt_q;
    pb_we = 1'b0; tx_byte = 8'd0;

    if (tx_req) begin
      if (phase_q == PH_RDATA) begin
        tx_byte = mem_rdata;
        addr_d  = addr_q + ADDR_W'(1);
      end else if (phase_q == PH_RSTAT) begin
        tx_byte = status;
      end
    end

    if (byte_done) begin
      case (phase_q)
        PH_OPC: begin
          if (busy_q && rx_byte != OP_RDSR) begin
            phase_d = PH_SKIP;
          end else begin
            case (rx_byte)
              OP_WREN:  begin wel_d = 1'b1; phase_d = PH_SKIP; end
              OP_WRDI:  begin wel_d = 1'b0; phase_d = PH_SKIP; end
              OP_RDSR:  phase_d = PH_RSTAT;
              OP_WRSR:  begin kind_d = 1'b1; phase_d = PH_WSTAT; end
              OP_READ:  begin rd_d = 1'b1; acnt_d = 2'd0; phase_d = PH_ADDR; end
              OP_WRITE: begin
                rd_d = 1'b0; kind_d = 1'b0; acnt_d = 2'd0;
                mask_d = '0; phase_d = PH_ADDR;
              end
              default:  phase_d = PH_SKIP;
            endcase
          end
        end
        PH_ADDR: begin
          addr_d = ADDR_W'({addr_q, rx_byte});
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            if (rd_q) begin
              phase_d = PH_RDATA;
            end else begin
              phase_d = PH_WDATA;
              wptr_d  = addr_d[PAGE_W-1:0];
              base_d  = addr_d[ADDR_W-1:PAGE_W];
            end
          end
        end
        PH_WDATA: begin
          pb_we          = 1'b1;
          mask_d[wptr_q] = 1'b1;
          wptr_d         = wptr_q + PAGE_W'(1);
          armed_d        = 1'b1;
        end
        PH_WSTAT: begin
          srd_d   = rx_byte[3:2];
          armed_d = 1'b1;
          phase_d = PH_SKIP;
        end
        default: ;
      endcase
    end

    if (busy_q) begin
      bcnt_d = bcnt_q + CNT_W'(1);
      if (bcnt_q == CNT_W'(BUSY_CYC - 1)) begin
        busy_d = 1'b0;
        wel_d  = 1'b0;
      end
    end

    if (csn) begin
      phase_d = PH_OPC;
      acnt_d  = 2'd0;
      armed_d = 1'b0;
      if (cs_rise && armed_q && bit_cnt == 3'd0 && wel_q && !busy_q && (!kind_q || wp_n)) begin
        busy_d = 1'b1;
        bcnt_d = '0;
        prog_d = ~kind_q;
        if (kind_q) bp_d = srd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC; acnt_q <= 2'd0; rd_q <= 1'b0; kind_q <= 1'b0;
      armed_q <= 1'b0; addr_q <= '0; wptr_q <= '0; base_q <= '0;
      mask_q <= '0; srd_q <= 2'd0; bp_q <= 2'd0; wel_q <= 1'b0;
      busy_q <= 1'b0; prog_q <= 1'b0; bcnt_q <= '0; csn_q <= 1'b1;
    end else begin
      phase_q <= phase_d; acnt_q <= acnt_d; rd_q <= rd_d; kind_q <= kind_d;
      armed_q <= armed_d; addr_q <= addr_d; wptr_q <= wptr_d; base_q <= base_d;
      mask_q <= mask_d; srd_q <= srd_d; bp_q <= bp_d; wel_q <= wel_d;
      busy_q <= busy_d; prog_q <= prog_d; bcnt_q <= bcnt_d; csn_q <= csn;
    end
  end

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[wptr_q] <= rx_byte;
  end

  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && byte_done && phase_q == PH_OPC && rx_byte != OP_RDSR) |=> (phase_q == PH_SKIP));
  assert_wel_clear_after_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q);
  assert_prog_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));
  assert_lock_guards_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && !prog_q) |-> $past(wp_n));
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 7,
  parameter int BUSY_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  output logic ser_dout_en,
  input  logic sr_lock_n,
  input  logic pause_n
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              rst_m, rst_i;
  logic              byte_done, tx_req, mem_we;
  logic [7:0]        rx_byte, tx_byte, mem_rdata, mem_wdata;
  logic [2:0]        bit_cnt;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [1:0]        bp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_i <= rst_m;
    end
  end

  eep_serial u_serial (
    .clk(clk), .rst_n(rst_i), .csn(sel_n), .sck(ser_clk), .mosi(ser_din),
    .hold_n(pause_n), .tx_byte(tx_byte), .byte_done(byte_done),
    .rx_byte(rx_byte), .tx_req(tx_req), .miso(ser_dout), .bit_cnt(bit_cnt)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .csn(sel_n), .wp_n(sr_lock_n), .hold_n(pause_n),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_req(tx_req), .bit_cnt(bit_cnt),
    .mem_rdata(mem_rdata), .tx_byte(tx_byte), .so_oe(ser_dout_en),
    .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .bp_o(bp)
  );

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assert_protected_untouched_R9: assert property (@(posedge clk) disable iff (!rst_i)
    mem_we |-> !((bp != 2'b00) && (int'(mem_waddr) >= DEPTH - (DEPTH >> (3 - int'(bp))))));
  assert_deselected_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(sel_n) |=> !ser_dout_en);
endmodule

// File: tb/tb_eep_spi_slave.sv
module tb_eep_spi_slave;
  localparam int ADDR_W = 9;
  localparam int PAGE_W = 4;
  localparam int BUSY   = 1000;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int HP     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, din = 1'b0, lock_n = 1'b1, pause_n = 1'b1;
  logic dout, dout_en;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [7:0] ref_mem [DEPTH];
  bit         ref_wel = 1'b0;
  logic [1:0] ref_bp = 2'b00;
  bit         prog_pend = 1'b0;

  always #10 clk = ~clk;

  eep_spi_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(sck), .ser_din(din),
    .ser_dout(dout), .ser_dout_en(dout_en), .sr_lock_n(lock_n), .pause_n(pause_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1: output stays released whenever deselected, checked every clock
  always @(negedge clk) begin
    if (rst_n && sel_n && !finished) check(dout_en == 1'b0, "R1 enable while deselected", dout_en, 0);
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit is_prot(input int a);
    if (ref_bp == 2'b00) return 1'b0;
    return a >= DEPTH - (DEPTH >> (3 - int'(ref_bp)));
  endfunction

  function automatic logic [7:0] dat(input int seed, input int k);
    return 8'(seed * 29 + k * 37 + 5);
  endfunction

  task automatic cs_low(input bit m3);
    sck = m3; clks(HP);
    sel_n = 1'b0; clks(HP);
  endtask

  task automatic cs_high(input bit m3);
    if (!m3) sck = 1'b0;
    clks(HP);
    sel_n = 1'b1; clks(HP);
  endtask

  task automatic xfer(input logic [7:0] tx, input int chk_oe, input int hold_bit,
                      input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sck = 1'b0; din = tx[i]; clks(HP);
      if (i == hold_bit) begin
        pause_n = 1'b0; clks(HP);
        check(dout_en == 1'b0, "R11 enable during pause", dout_en, 0);
        sck = 1'b1; din = ~din; clks(HP);
        sck = 1'b0; clks(HP);
        pause_n = 1'b1; clks(HP);
      end
      rx[i] = dout;
      if (chk_oe >= 0) check(dout_en == chk_oe[0], "R7/R8 output enable", dout_en, chk_oe);
      sck = 1'b1; clks(HP);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input bit m3);
    logic [7:0] r;
    cs_low(m3); xfer(op, -1, -1, 8, r); cs_high(m3);
    if (!prog_pend) begin
      if (op == 8'h06) ref_wel = 1'b1;
      if (op == 8'h04) ref_wel = 1'b0;
    end
  endtask

  task automatic status_is(input logic [7:0] exp, input bit m3, input string req);
    logic [7:0] r;
    cs_low(m3); xfer(8'h05, -1, -1, 8, r); xfer(8'h00, 1, -1, 8, r); cs_high(m3);
    check(r == exp, req, r, exp);
  endtask

  task automatic wait_prog();
    clks(BUSY + 20);
    if (prog_pend) ref_wel = 1'b0;
    prog_pend = 1'b0;
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r;
    xfer(a[23:16], -1, -1, 8, r); xfer(a[15:8], -1, -1, 8, r); xfer(a[7:0], -1, -1, 8, r);
  endtask

  task automatic page_write(input logic [23:0] a, input int n, input int seed,
                            input int cut, input bit m3);
    logic [7:0] r;
    logic [7:0] stage [PAGE];
    bit         has [PAGE];
    int base, off;
    for (int o = 0; o < PAGE; o++) begin has[o] = 1'b0; stage[o] = 8'h00; end
    base = int'(a) & (DEPTH - 1) & ~(PAGE - 1);
    off  = int'(a) & (PAGE - 1);
    cs_low(m3); xfer(8'h02, -1, -1, 8, r); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xfer(dat(seed, k), -1, -1, 8, r);
      stage[off] = dat(seed, k); has[off] = 1'b1; off = (off + 1) % PAGE;
    end
    if (cut > 0) xfer(8'hA5, -1, -1, cut, r);
    cs_high(m3);
    if (ref_wel && !prog_pend && n > 0 && cut == 0) begin
      for (int o = 0; o < PAGE; o++)
        if (has[o] && !is_prot(base + o)) ref_mem[base + o] = stage[o];
      prog_pend = 1'b1;
    end
  endtask

  task automatic status_write(input logic [7:0] v, input bit m3);
    logic [7:0] r;
    cs_low(m3); xfer(8'h01, -1, -1, 8, r); xfer(v, -1, -1, 8, r); cs_high(m3);
    if (ref_wel && !prog_pend && lock_n) begin
      ref_bp = v[3:2];
      prog_pend = 1'b1;
    end
  endtask

  task automatic read_seq(input logic [23:0] a, input int n, input bit m3,
                          input int hold_byte, input int hold_bit, input string req);
    logic [7:0] r;
    int ad;
    cs_low(m3); xfer(8'h03, -1, -1, 8, r); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 1, (k == hold_byte) ? hold_bit : -1, 8, r);
      ad = (int'(a) + k) % DEPTH;
      check(r == ref_mem[ad], req, r, ref_mem[ad]);
    end
    cs_high(m3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R1 watchdog expired actual %0d expected %0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] r;
    clks(3); rst_n = 1'b1; clks(5);

    status_is(8'h00, 1'b0, "R1 reset status");

    cmd(8'h06, 1'b0);
    status_is(8'h02, 1'b0, "R3 enable flag set");
    cmd(8'h04, 1'b1);
    status_is(8'h00, 1'b1, "R2 R3 mode 3 flag clear");

    // R7: busy visible, other commands ignored
    cmd(8'h06, 1'b0);
    page_write(24'h000020, 16, 1, 0, 1'b0);
    status_is(8'h03, 1'b0, "R7 busy and enable during programming");
    cs_low(1'b0); xfer(8'h03, -1, -1, 8, r); send_addr(24'h000020);
    xfer(8'h00, 0, -1, 8, r); cs_high(1'b0);
    wait_prog();
    status_is(8'h00, 1'b0, "R7 enable cleared after programming");
    cmd(8'h06, 1'b0);
    page_write(24'h000030, 16, 2, 0, 1'b0);
    wait_prog();
    read_seq(24'h000020, 32, 1'b0, -1, -1, "R8 read increments across pages");

    // R4: no enable, no change
    page_write(24'h000020, 16, 3, 0, 1'b0);
    clks(50);
    status_is(8'h00, 1'b0, "R4 status unchanged");
    read_seq(24'h000020, 16, 1'b0, -1, -1, "R4 write without enable ignored");

    // R5: wrap inside page
    cmd(8'h06, 1'b0);
    page_write(24'h00002C, 20, 4, 0, 1'b0);
    wait_prog();
    read_seq(24'h000020, 32, 1'b0, -1, -1, "R5 page wrap keeps next page");

    // R6: aborted writes
    cmd(8'h06, 1'b0);
    page_write(24'h000024, 5, 5, 3, 1'b0);
    clks(50);
    status_is(8'h02, 1'b0, "R6 mid-byte abort keeps enable");
    page_write(24'h000024, 0, 5, 0, 1'b1);
    clks(50);
    status_is(8'h02, 1'b0, "R6 no-data abort keeps enable");
    read_seq(24'h000020, 16, 1'b0, -1, -1, "R6 aborted write left data");
    cmd(8'h04, 1'b0);

    // R12, R8: upper address bits ignored, array-end wrap
    cmd(8'h06, 1'b0); page_write(24'hFF01F0, 16, 6, 0, 1'b0); wait_prog();
    cmd(8'h06, 1'b1); page_write(24'h000000, 16, 7, 0, 1'b1); wait_prog();
    cmd(8'h06, 1'b0); page_write(24'h000100, 16, 10, 0, 1'b0); wait_prog();
    read_seq(24'h7F01FE, 4, 1'b1, -1, -1, "R8 R12 wrap at array end");

    // R10, R9: quarter
    cmd(8'h06, 1'b0); status_write(8'h04, 1'b0); wait_prog();
    status_is(8'h04, 1'b0, "R10 protect field written");
    cmd(8'h06, 1'b0); page_write(24'h0001F0, 16, 8, 0, 1'b0); wait_prog();
    cmd(8'h06, 1'b0); page_write(24'h000100, 16, 11, 0, 1'b0); wait_prog();
    read_seq(24'h0001F0, 16, 1'b0, -1, -1, "R9 top quarter protected");
    read_seq(24'h000100, 16, 1'b0, -1, -1, "R9 below quarter writable");
    // half
    cmd(8'h06, 1'b0); status_write(8'h08, 1'b0); wait_prog();
    cmd(8'h06, 1'b0); page_write(24'h000100, 16, 12, 0, 1'b0); wait_prog();
    cmd(8'h06, 1'b0); page_write(24'h0000F0, 16, 13, 0, 1'b0); wait_prog();
    read_seq(24'h0000F0, 32, 1'b0, -1, -1, "R9 half boundary");
    // whole
    cmd(8'h06, 1'b0); status_write(8'h0C, 1'b0); wait_prog();
    cmd(8'h06, 1'b0); page_write(24'h000000, 16, 14, 0, 1'b0); wait_prog();
    read_seq(24'h000000, 16, 1'b0, -1, -1, "R9 whole array protected");

    // R10: lock pin
    lock_n = 1'b0;
    cmd(8'h06, 1'b0); status_write(8'h00, 1'b0); clks(50);
    status_is(8'h0E, 1'b0, "R10 locked status write discarded");
    lock_n = 1'b1;
    status_write(8'h00, 1'b0); wait_prog();
    status_is(8'h00, 1'b0, "R10 unlocked status write");

    // R11: pause mid-byte in both modes
    read_seq(24'h000020, 3, 1'b0, 1, 4, "R11 pause resumes read");
    read_seq(24'h000030, 3, 1'b1, 0, 2, "R11 pause resumes read mode 3");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule